// File: doc/BRIEF.md
# Real-Time-Clock Alarm Matcher

This block decides when a real-time clock's alarm goes off. On every one-second strobe it compares the running BCD time (day of month, hour, minute, second) against four alarm registers. A four-bit repeat code selects which of those fields must agree. A match raises a sticky alarm flag. Software clears the flag by reading the flags register. When the alarm interrupt is enabled, the flag drives an active-low interrupt request.

The same request pin also carries a 512 Hz frequency-test square wave, which is used for oscillator trimming in production. The square wave is routed to the pin only under a strict gating condition. The frequency-test enable bit is held inside the block, is written by a strobe, and is cleared when power fails. The flag is kept by a two-state machine:
- `FS_CLEAR` moves to `FS_RAISED` on transition RAISE, which is a qualifying match on a strobe.
- `FS_RAISED` stays in place on transition HOLD, which is a match arriving in the same cycle as a read.
- `FS_RAISED` returns to `FS_CLEAR` on transition DROP, which is a read with no match.

Top module: `rtc_alarm_matcher`

## Requirements
- R1: While reset is held and right after it, `alarm_flag` is 0, `irq_n` is 1 and the frequency-test bit is 0.
- R2: With `rep_bits` = 4'b0000 and a nonzero `alm_date`, the flag sets on a strobe only when day, hour, minute and second all equal their alarm values.
- R3: With `rep_bits` = 4'b1000 (daily), the flag sets when hour, minute and second match. The day is ignored.
- R4: With `rep_bits` = 4'b1100 (hourly), the flag sets when minute and second match.
- R5: With `rep_bits` = 4'b1110 (each minute), the flag sets when the second matches.
- R6: With `rep_bits` = 4'b1111, and with any code not listed in R2 to R5, the flag sets on every strobe.
- R7: With `rep_bits` = 4'b0000 and `alm_date` = 0, the alarm never sets.
- R8: Matching happens only in a cycle where `sec_tick` is 1. Equal fields without a strobe set nothing.
- R9: A `flags_rd` pulse with no match in the same cycle clears the flag from the next cycle on, and `irq_n` returns to 1.
- R10: A match in the same cycle as `flags_rd` wins, and the flag stays set.
- R11: When the test gate of R12 is closed, `irq_n` is 0 exactly when the flag is set and `irq_en` is 1.
- R12: `irq_n` follows `sq512` when `stop_osc` = 0, the frequency-test bit = 1, `irq_en` = 0, and either `wd_steer` = 1 or `wd_reg` = 0.
- R13: `ft_we` loads `ft_wdata` into the frequency-test bit. `power_down` clears it, and `power_down` takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cur_date | input | 6 | Current day of month, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_sec | input | 7 | Current second, BCD |
| alm_date | input | 6 | Alarm day of month, BCD |
| alm_hour | input | 6 | Alarm hour, BCD |
| alm_min | input | 7 | Alarm minute, BCD |
| alm_sec | input | 7 | Alarm second, BCD |
| rep_bits | input | 4 | Repeat code; bit 3 comes from the date register, bit 0 from the seconds register |
| irq_en | input | 1 | Alarm interrupt enable |
| flags_rd | input | 1 | Flags-register read strobe |
| stop_osc | input | 1 | Oscillator stop bit |
| ft_we | input | 1 | Write strobe for the frequency-test bit |
| ft_wdata | input | 1 | Value written to the frequency-test bit |
| power_down | input | 1 | Power-fail pulse |
| wd_steer | input | 1 | Watchdog steering bit |
| wd_reg | input | 8 | Watchdog register contents |
| sq512 | input | 1 | 512 Hz square wave from the divider |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low request pin (alarm or test wave) |

## Verification
The bench walks through every repeat code with exactly one field out of step. A decoder that mapped a code to the wrong mode would either raise the flag on that stray field or miss a genuine match. It also uses illegal codes and the all-zero disable pattern. A decoder without the once-per-second fallback would stay silent on the illegal codes, and one without the disable case would fire on day 0. The bench drives a read and a match into the same cycle; a design that favoured the read would drop the flag. Finally, it sweeps each term of the test-gate condition and drives a power-fail pulse together with a write. A gate that missed one term would leak the square wave onto the pin or hide the alarm.

// File: rtl/rtc_alm_pkg.sv
`timescale 1ns/1ps
package rtc_alm_pkg;

    typedef enum logic [2:0] {
        RM_DATE,
        RM_DAY,
        RM_HOUR,
        RM_MIN,
        RM_SEC,
        RM_OFF
    } rep_mode_t;

    typedef enum logic {
        FS_CLEAR,
        FS_RAISED
    } flag_state_t;

    localparam int REP_W = 4;

endpackage

// File: rtl/rtc_alm_mode_dec.sv
`timescale 1ns/1ps
module rtc_alm_mode_dec
    import rtc_alm_pkg::*;
#(
    parameter int DATE_W = 6
) (
    input  logic [REP_W-1:0]  rep_bits,
    input  logic [DATE_W-1:0] alm_date,
    output rep_mode_t         mode
);

    // Repeat bits fill from the top down; any other pattern falls back to each second.
    always_comb begin
        unique case (rep_bits)
            4'b0000: mode = (alm_date == '0) ? RM_OFF : RM_DATE;
            4'b1000: mode = RM_DAY;
            4'b1100: mode = RM_HOUR;
            4'b1110: mode = RM_MIN;
            default: mode = RM_SEC;
        endcase
    end

endmodule

// File: rtl/rtc_alm_field_eq.sv
`timescale 1ns/1ps
module rtc_alm_field_eq #(
    parameter int W = 7
) (
    input  logic [W-1:0] now_val,
    input  logic [W-1:0] set_val,
    input  logic         care,
    output logic         ok
);

    assign ok = !care || (now_val == set_val);

endmodule

// File: rtl/rtc_alm_cmp.sv
`timescale 1ns/1ps
module rtc_alm_cmp
    import rtc_alm_pkg::*;
#(
    parameter int DATE_W = 6,
    parameter int HOUR_W = 6,
    parameter int MIN_W  = 7,
    parameter int SEC_W  = 7
) (
    input  rep_mode_t         mode,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [DATE_W-1:0] alm_date,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [SEC_W-1:0]  alm_sec,
    output logic              match
);

    localparam int NFIELD = 4;

    logic [NFIELD-1:0] care;
    logic [NFIELD-1:0] ok;

    // care: bit3 day, bit2 hour, bit1 minute, bit0 second
    always_comb begin
        unique case (mode)
            RM_DATE: care = 4'b1111;
            RM_DAY:  care = 4'b0111;
            RM_HOUR: care = 4'b0011;
            RM_MIN:  care = 4'b0001;
            default: care = 4'b0000;
        endcase
    end

    rtc_alm_field_eq #(.W(DATE_W)) u_eq_date (
        .now_val(cur_date), .set_val(alm_date), .care(care[3]), .ok(ok[3]));
    rtc_alm_field_eq #(.W(HOUR_W)) u_eq_hour (
        .now_val(cur_hour), .set_val(alm_hour), .care(care[2]), .ok(ok[2]));
    rtc_alm_field_eq #(.W(MIN_W))  u_eq_min (
        .now_val(cur_min),  .set_val(alm_min),  .care(care[1]), .ok(ok[1]));
    rtc_alm_field_eq #(.W(SEC_W))  u_eq_sec (
        .now_val(cur_sec),  .set_val(alm_sec),  .care(care[0]), .ok(ok[0]));

    assign match = (mode != RM_OFF) && (&ok);

endmodule

// File: rtl/rtc_alm_ftgate.sv
`timescale 1ns/1ps
module rtc_alm_ftgate #(
    parameter int WD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ft_we,
    input  logic            ft_wdata,
    input  logic            power_down,
    input  logic            stop_osc,
    input  logic            irq_en,
    input  logic            wd_steer,
    input  logic [WD_W-1:0] wd_reg,
    output logic            gate_open
);

    logic ft_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ft_q <= 1'b0;
        end else if (power_down) begin
            ft_q <= 1'b0;
        end else if (ft_we) begin
            ft_q <= ft_wdata;
        end
    end

    assign gate_open = !stop_osc && ft_q && !irq_en && (wd_steer || (wd_reg == '0));

endmodule

// File: rtl/rtc_alarm_matcher.sv
`timescale 1ns/1ps
module rtc_alarm_matcher
    import rtc_alm_pkg::*;
#(
    parameter int DATE_W = 6,
    parameter int HOUR_W = 6,
    parameter int MIN_W  = 7,
    parameter int SEC_W  = 7,
    parameter int WD_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [DATE_W-1:0] alm_date,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [SEC_W-1:0]  alm_sec,
    input  logic [3:0]        rep_bits,
    input  logic              irq_en,
    input  logic              flags_rd,
    input  logic              stop_osc,
    input  logic              ft_we,
    input  logic              ft_wdata,
    input  logic              power_down,
    input  logic              wd_steer,
    input  logic [WD_W-1:0]   wd_reg,
    input  logic              sq512,
    output logic              alarm_flag,
    output logic              irq_n
);

    rep_mode_t   mode;
    logic        match;
    logic        hit;
    logic        ft_gate;
    flag_state_t state_q;
    flag_state_t state_d;

    rtc_alm_mode_dec #(.DATE_W(DATE_W)) u_dec (
        .rep_bits(rep_bits),
        .alm_date(alm_date),
        .mode    (mode)
    );

    rtc_alm_cmp #(
        .DATE_W(DATE_W), .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)
    ) u_cmp (
        .mode    (mode),
        .cur_date(cur_date), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .match   (match)
    );

    rtc_alm_ftgate #(.WD_W(WD_W)) u_ft (
        .clk       (clk),
        .rst_n     (rst_n),
        .ft_we     (ft_we),
        .ft_wdata  (ft_wdata),
        .power_down(power_down),
        .stop_osc  (stop_osc),
        .irq_en    (irq_en),
        .wd_steer  (wd_steer),
        .wd_reg    (wd_reg),
        .gate_open (ft_gate)
    );

    assign hit = sec_tick && match;

    // Transitions: RAISE (hit), HOLD (hit beats read), DROP (read alone).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAR:  if (hit) state_d = FS_RAISED;
            FS_RAISED: if (flags_rd && !hit) state_d = FS_CLEAR;
            default:   state_d = FS_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        alarm_flag = (state_q == FS_RAISED);
        if (ft_gate) begin
            irq_n = sq512;
        end else begin
            irq_n = !(alarm_flag && irq_en);
        end
    end

endmodule

// File: rtl/rtc_alarm_chk.sv
`timescale 1ns/1ps
module rtc_alarm_chk
    import rtc_alm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       flags_rd,
    input logic       irq_en,
    input logic       power_down,
    input logic       hit,
    input logic [2:0] mode,
    input logic       ft_gate,
    input logic       ft_bit,
    input logic       alarm_flag,
    input logic       irq_n
);

    AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_OFF) |-> !hit); // R7

    AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !alarm_flag) |=> !alarm_flag); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !hit) |=> !alarm_flag); // R9

    AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag); // R10

    AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && irq_en) |-> !irq_n); // R11

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !ft_gate) |-> irq_n); // R11

    AST_PD_CLEARS_FT: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> !ft_bit); // R13

endmodule

bind rtc_alarm_matcher rtc_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .flags_rd  (flags_rd),
    .irq_en    (irq_en),
    .power_down(power_down),
    .hit       (hit),
    .mode      (mode),
    .ft_gate   (ft_gate),
    .ft_bit    (u_ft.ft_q),
    .alarm_flag(alarm_flag),
    .irq_n     (irq_n)
);

// File: tb/tb_rtc_alarm_matcher.sv
`timescale 1ns/1ps
module tb_rtc_alarm_matcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [5:0] cur_date = '0, alm_date = '0, cur_hour = '0, alm_hour = '0;
    logic [6:0] cur_min = '0, alm_min = '0, cur_sec = '0, alm_sec = '0;
    logic [3:0] rep_bits = '0;
    logic       irq_en = 1'b0, flags_rd = 1'b0, stop_osc = 1'b0;
    logic       ft_we = 1'b0, ft_wdata = 1'b0, power_down = 1'b0;
    logic       wd_steer = 1'b0, sq512 = 1'b0;
    logic [7:0] wd_reg = '0;
    logic       alarm_flag, irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_flag = 0;
    bit m_ft = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_matcher dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_date(cur_date), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .rep_bits(rep_bits), .irq_en(irq_en), .flags_rd(flags_rd), .stop_osc(stop_osc),
        .ft_we(ft_we), .ft_wdata(ft_wdata), .power_down(power_down),
        .wd_steer(wd_steer), .wd_reg(wd_reg), .sq512(sq512),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic bit ref_hit();
        int need;
        if (!sec_tick) return 1'b0;
        if (rep_bits == 4'b0000) need = (alm_date == 0) ? -1 : 4;
        else if (rep_bits == 4'b1000) need = 3;
        else if (rep_bits == 4'b1100) need = 2;
        else if (rep_bits == 4'b1110) need = 1;
        else need = 0;
        if (need < 0) return 1'b0;
        return (need < 1 || cur_sec == alm_sec) && (need < 2 || cur_min == alm_min) &&
               (need < 3 || cur_hour == alm_hour) && (need < 4 || cur_date == alm_date);
    endfunction

    function automatic bit ref_irq();
        bit gate;
        gate = !stop_osc && m_ft && !irq_en && (wd_steer || wd_reg == 0);
        return gate ? sq512 : !(m_flag && irq_en);
    endfunction

    task automatic step(input string req);
        bit nf, nft, ei;
        #1;
        if (!rst_n) begin m_flag = 0; m_ft = 0; end
        ei = ref_irq();
        n_cmp++;
        if (alarm_flag !== m_flag) begin
            n_bad++;
            $display("FAIL %s alarm_flag got %0b expected %0b", req, alarm_flag, m_flag);
        end
        n_cmp++;
        if (irq_n !== ei) begin
            n_bad++;
            $display("FAIL %s irq_n got %0b expected %0b", req, irq_n, ei);
        end
        nf  = !rst_n ? 1'b0 : (ref_hit() ? 1'b1 : (flags_rd ? 1'b0 : m_flag));
        nft = !rst_n ? 1'b0 : (power_down ? 1'b0 : (ft_we ? ft_wdata : m_ft));
        @(posedge clk);
        m_flag = nf;
        m_ft = nft;
        @(negedge clk);
        sec_tick = 0; flags_rd = 0; ft_we = 0; power_down = 0;
        sq512 = ~sq512;
    endtask

    task automatic set_now_to_alarm();
        cur_date = alm_date; cur_hour = alm_hour; cur_min = alm_min; cur_sec = alm_sec;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1'b1;
        step("R1");

        // full date match
        alm_date = 6'h15; alm_hour = 6'h08; alm_min = 7'h30; alm_sec = 7'h45;
        rep_bits = 4'b0000;
        set_now_to_alarm();
        step("R8"); step("R8");
        sec_tick = 1; step("R2");
        step("R2");
        flags_rd = 1; step("R9");
        step("R9");
        cur_sec = 7'h46; sec_tick = 1; step("R2");
        cur_sec = 7'h45; cur_date = 6'h16; sec_tick = 1; step("R2");
        cur_date = 6'h15; cur_hour = 6'h09; sec_tick = 1; step("R2");
        step("R2");

        // interrupt follows flag when enabled
        irq_en = 1; set_now_to_alarm();
        sec_tick = 1; step("R11");
        step("R11");
        flags_rd = 1; step("R11");
        step("R11");

        // daily
        rep_bits = 4'b1000; cur_date = 6'h02; sec_tick = 1; step("R3");
        step("R3");
        flags_rd = 1; step("R3");
        cur_hour = 6'h10; sec_tick = 1; step("R3");
        step("R3");

        // hourly
        rep_bits = 4'b1100; sec_tick = 1; step("R4");
        flags_rd = 1; step("R4");
        cur_min = 7'h31; sec_tick = 1; step("R4");
        step("R4");

        // each minute
        rep_bits = 4'b1110; sec_tick = 1; step("R5");
        flags_rd = 1; step("R5");
        cur_sec = 7'h12; sec_tick = 1; step("R5");
        step("R5");

        // each second and illegal codes
        rep_bits = 4'b1111; sec_tick = 1; step("R6");
        flags_rd = 1; step("R6");
        rep_bits = 4'b0101; sec_tick = 1; step("R6");
        flags_rd = 1; step("R6");
        rep_bits = 4'b0001; sec_tick = 1; step("R6");
        flags_rd = 1; step("R6");
        rep_bits = 4'b1011; sec_tick = 1; step("R6");
        flags_rd = 1; step("R6");
        step("R6");

        // disabled alarm
        rep_bits = 4'b0000; alm_date = 6'h00; set_now_to_alarm();
        sec_tick = 1; step("R7");
        step("R7");
        sec_tick = 1; step("R7");

        // read and hit in the same cycle
        rep_bits = 4'b1111;
        sec_tick = 1; step("R10");
        sec_tick = 1; flags_rd = 1; step("R10");
        step("R10");
        flags_rd = 1; step("R10");
        step("R10");

        // frequency-test gating
        irq_en = 0; stop_osc = 0; wd_steer = 1; wd_reg = 8'h00;
        ft_we = 1; ft_wdata = 1; step("R12");
        step("R12"); step("R12"); step("R12");
        wd_steer = 0; wd_reg = 8'h3c; step("R12"); step("R12");
        wd_reg = 8'h00; step("R12"); step("R12");
        wd_steer = 1; wd_reg = 8'h81; step("R12"); step("R12");
        stop_osc = 1; step("R12"); step("R12");
        stop_osc = 0; sec_tick = 1; step("R12");
        irq_en = 1; step("R12"); step("R12");
        irq_en = 0; flags_rd = 1; step("R12"); step("R12");

        // test bit cleared by power failure
        power_down = 1; step("R13");
        step("R13"); step("R13");
        ft_we = 1; ft_wdata = 1; step("R13");
        step("R13");
        ft_we = 1; ft_wdata = 1; power_down = 1; step("R13");
        step("R13"); step("R13");
        ft_we = 1; ft_wdata = 1; step("R13");
        ft_we = 1; ft_wdata = 0; step("R13");
        step("R13"); step("R13");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule